// File: doc/BRIEF.md
# SPI FIFO Flag and DMA Controller

This block holds the transmit and receive queues that sit between a host bus and an SPI shift engine able to act as clock master or as slave. The host writes characters into the transmit queue and reads received characters out of the receive queue. The shift engine takes transmit characters and hands back received ones through single-cycle strobes. From the traffic on both sides the block derives a set of sticky interrupt flags, a transmit-level DMA request and, in master mode, a clock-stall signal. The stall replaces the error flags that a slave would raise.

The host side provides a one-cycle flush strobe for the transmit queue, a transmit enable, a transmit threshold and a write-one-to-clear vector for the flags. The engine side provides a mode bit, the slave-select level, a per-bit shift tick and a character-complete strobe. Both queues present their head word combinationally.

Top module: `spi_fifo_ctl`

## Requirements
- R1: A cycle with `ctl_tx_flush` high empties the transmit queue by the next edge and drops any host write or engine pop made in that cycle. At that edge flags tx_level (bit 1), tx_ovr (bit 2) and tx_udr (bit 3) clear, and tx_empty (bit 0) is set. With `ctl_tx_flush` low the queue is untouched.
- R2: While `ctl_tx_en` is low, host writes are discarded without any flag, `eng_tx_avail` is low, engine pops remove nothing and `tx_dma_req` is low.
- R3: `tx_dma_req` is high exactly when `ctl_tx_en` is high and the transmit count is strictly below `ctl_tx_thresh`. In that case tx_level (bit 1) is set at the next edge.
- R4: A host read of an empty receive queue sets rx_udr (bit 5) in both modes.
- R5: An engine push into a full receive queue discards the data. In slave mode it sets rx_ovr (bit 4). In master mode it raises `eng_clk_stall` in that cycle and leaves bit 4 alone.
- R6: An engine pop with no transmit data available (queue empty or disabled) sets tx_udr (bit 3) in slave mode. In master mode it raises `eng_clk_stall` in that cycle and leaves bit 3 alone.
- R7: A host write while enabled into a full transmit queue is discarded and sets tx_ovr (bit 2) in either mode.
- R8: In master mode, a character-complete strobe while the transmit queue is empty sets m_done (bit 6).
- R9: In slave mode, a falling edge of `eng_ss_active` while a character is partly shifted sets s_abort (bit 7). A character counts as partly shifted after a bit tick and until a character-complete strobe or the slave-select fall.
- R10: Flags reset to 0. They are sticky, and a 1 in `irq_clr` clears the matching bit. A set condition in the same cycle wins over the clear. tx_empty (bit 0) is set every cycle the transmit queue is empty.
- R11: Each queue returns characters in write order. `tx_count` and `rx_count` track occupancy, and a push and a pop in the same cycle are both honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_tx_flush | input | 1 | One-cycle strobe that empties the transmit queue |
| ctl_tx_en | input | 1 | Transmit queue enable |
| ctl_tx_thresh | input | CW | Transmit DMA threshold |
| host_tx_wr | input | 1 | Host write strobe into the transmit queue |
| host_tx_data | input | DW | Host write data |
| host_rx_rd | input | 1 | Host read strobe from the receive queue |
| host_rx_data | output | DW | Head of the receive queue |
| irq_clr | input | 8 | Write-one-to-clear mask for the flags |
| irq_flags | output | 8 | Sticky interrupt flags |
| tx_dma_req | output | 1 | Transmit-level DMA request |
| tx_count | output | CW | Transmit queue occupancy |
| rx_count | output | CW | Receive queue occupancy |
| eng_master | input | 1 | 1 = master mode, 0 = slave mode |
| eng_tx_pop | input | 1 | Engine takes a transmit character |
| eng_tx_data | output | DW | Head of the transmit queue |
| eng_tx_avail | output | 1 | Transmit character available to the engine |
| eng_rx_push | input | 1 | Engine delivers a received character |
| eng_rx_data | input | DW | Received character |
| eng_bit_tick | input | 1 | One bit shifted |
| eng_char_done | input | 1 | One full character shifted |
| eng_ss_active | input | 1 | Slave-select asserted (active level 1) |
| eng_clk_stall | output | 1 | Master-mode request to hold the serial clock |

## Verification
The bench builds the block with a depth of 4 and 8-bit data, so the count width is 3 and the threshold spans 0 to 4. A shallow queue makes the random traffic reach the full and empty boundaries every few cycles, and the overrun, underrun, stall and threshold-edge cases all occur often. The mode bit flips every 200 cycles, so every error condition is seen both as a flag in slave mode and as a stall in master mode.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int FLAG_N = 8;

    typedef struct packed {
        logic s_abort;   // bit 7
        logic m_done;    // bit 6
        logic rx_udr;    // bit 5
        logic rx_ovr;    // bit 4
        logic tx_udr;    // bit 3
        logic tx_ovr;    // bit 2
        logic tx_level;  // bit 1
        logic tx_empty;  // bit 0
    } irq_vec_t;

    typedef enum logic {
        MODE_SLAVE  = 1'b0,
        MODE_MASTER = 1'b1
    } spi_mode_e;

    // Flags wiped by a transmit flush (tx_empty is then forced set).
    function automatic irq_vec_t tx_group_mask();
        irq_vec_t m;
        m          = '0;
        m.tx_level = 1'b1;
        m.tx_ovr   = 1'b1;
        m.tx_udr   = 1'b1;
        return m;
    endfunction

    function automatic int cnt_width(int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = spi_fifo_pkg::cnt_width(DEPTH),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r11_no_push_full: assert property (@(posedge clk) disable iff (rst)
        !(push && full));
    a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        !(pop && empty));
    a_r11_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |=> count == $past(count) + CW'(1));

endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank
    import spi_fifo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t set_vec,
    input  irq_vec_t clr_vec,
    input  logic     tx_flush,
    output irq_vec_t flags
);
    irq_vec_t flags_n;

    always_comb begin
        flags_n = (flags & ~clr_vec) | set_vec;
        if (tx_flush) begin
            flags_n          = flags_n & ~tx_group_mask();
            flags_n.tx_empty = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_n;
    end

    a_r10_sticky_done: assert property (@(posedge clk) disable iff (rst)
        (flags.m_done && !clr_vec.m_done) |=> flags.m_done);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec.s_abort && clr_vec.s_abort) |=> flags.s_abort);
    a_r1_flush_marks_empty: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (flags.tx_empty && !flags.tx_ovr && !flags.tx_udr));

endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
    import spi_fifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int CW   = cnt_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_tx_flush,
    input  logic          ctl_tx_en,
    input  logic [CW-1:0] ctl_tx_thresh,
    input  logic          host_tx_wr,
    input  logic [DW-1:0] host_tx_data,
    input  logic          host_rx_rd,
    output logic [DW-1:0] host_rx_data,
    input  logic [7:0]    irq_clr,
    output logic [7:0]    irq_flags,
    output logic          tx_dma_req,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count,
    input  logic          eng_master,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_avail,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    input  logic          eng_bit_tick,
    input  logic          eng_char_done,
    input  logic          eng_ss_active,
    output logic          eng_clk_stall
);
    spi_mode_e mode;
    logic      tx_full, tx_empty, rx_full, rx_empty;
    logic      tx_push, tx_pop, rx_push, rx_pop;
    logic      ss_q, ss_fall, char_open;
    irq_vec_t  set_vec, flag_q;

    assign mode = spi_mode_e'(eng_master);

    // Transmit queue
    assign eng_tx_avail = ctl_tx_en && !tx_empty;
    assign tx_push      = host_tx_wr && ctl_tx_en && !tx_full && !ctl_tx_flush;
    assign tx_pop       = eng_tx_pop && eng_tx_avail && !ctl_tx_flush;

    spi_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (ctl_tx_flush),
        .push      (tx_push),
        .push_data (host_tx_data),
        .pop       (tx_pop),
        .head_data (eng_tx_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    // Receive queue
    assign rx_push = eng_rx_push && !rx_full;
    assign rx_pop  = host_rx_rd && !rx_empty;

    spi_fifo_buf #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (1'b0),
        .push      (rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head_data (host_rx_data),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // DMA request and master clock stall
    assign tx_dma_req    = ctl_tx_en && (tx_count < ctl_tx_thresh);
    assign eng_clk_stall = (mode == MODE_MASTER) &&
                           ((eng_tx_pop && !eng_tx_avail) || (eng_rx_push && rx_full));

    // Partial-character tracking for slave abort
    assign ss_fall = ss_q && !eng_ss_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_q      <= 1'b0;
            char_open <= 1'b0;
        end else begin
            ss_q <= eng_ss_active;
            if (ss_fall || eng_char_done) char_open <= 1'b0;
            else if (eng_bit_tick)        char_open <= 1'b1;
        end
    end

    // Flag set conditions
    always_comb begin
        set_vec          = '0;
        set_vec.tx_empty = tx_empty;
        set_vec.tx_level = tx_dma_req;
        set_vec.tx_ovr   = host_tx_wr && ctl_tx_en && tx_full;
        set_vec.tx_udr   = (mode == MODE_SLAVE) && eng_tx_pop && !eng_tx_avail;
        set_vec.rx_ovr   = (mode == MODE_SLAVE) && eng_rx_push && rx_full;
        set_vec.rx_udr   = host_rx_rd && rx_empty;
        set_vec.m_done   = (mode == MODE_MASTER) && eng_char_done && tx_empty;
        set_vec.s_abort  = (mode == MODE_SLAVE) && ss_fall && char_open;
    end

    spi_flag_bank u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (irq_vec_t'(irq_clr)),
        .tx_flush (ctl_tx_flush),
        .flags    (flag_q)
    );

    assign irq_flags = flag_q;

    a_r5_master_no_rx_ovr: assert property (@(posedge clk) disable iff (rst)
        (eng_master && eng_rx_push && rx_count == CW'(DEPTH) && !irq_flags[4]) |=> !irq_flags[4]);
    a_r6_master_no_tx_udr: assert property (@(posedge clk) disable iff (rst)
        (eng_master && eng_tx_pop && !eng_tx_avail && !irq_flags[3]) |=> !irq_flags[3]);
    a_r3_level_flag: assert property (@(posedge clk) disable iff (rst)
        (tx_dma_req && !ctl_tx_flush) |=> irq_flags[1]);
    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl_tx_en && !ctl_tx_flush) |=> tx_count == $past(tx_count));
    a_r7_full_write: assert property (@(posedge clk) disable iff (rst)
        (host_tx_wr && ctl_tx_en && tx_count == CW'(DEPTH) && !ctl_tx_flush) |=> irq_flags[2]);
    a_r1_flush_empties: assert property (@(posedge clk) disable iff (rst)
        ctl_tx_flush |=> tx_count == '0);

endmodule

// File: tb/sim_spi_fifo_ctl.sv
`timescale 1ns/1ps
module sim_spi_fifo_ctl;
    localparam int DW = 8;
    localparam int D  = 4;
    localparam int CW = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          flush, en, wr, rd, master, pop, push, btick, cdone, ss;
    logic [CW-1:0] thresh;
    logic [DW-1:0] wdata, pdata;
    logic [7:0]    clr;
    logic [DW-1:0] host_rx_data, eng_tx_data;
    logic [7:0]    irq_flags;
    logic          tx_dma_req, eng_tx_avail, eng_clk_stall;
    logic [CW-1:0] tx_count, rx_count;

    spi_fifo_ctl #(.DW(DW), .DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .ctl_tx_flush(flush), .ctl_tx_en(en),
        .ctl_tx_thresh(thresh), .host_tx_wr(wr), .host_tx_data(wdata),
        .host_rx_rd(rd), .host_rx_data(host_rx_data), .irq_clr(clr),
        .irq_flags(irq_flags), .tx_dma_req(tx_dma_req), .tx_count(tx_count),
        .rx_count(rx_count), .eng_master(master), .eng_tx_pop(pop),
        .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .eng_rx_push(push), .eng_rx_data(pdata), .eng_bit_tick(btick),
        .eng_char_done(cdone), .eng_ss_active(ss), .eng_clk_stall(eng_clk_stall)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];
    logic [7:0]    mflags;
    logic          m_ssq, m_open;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string ftag(int b);
        case (b)
            0: return "R1 R10 tx_empty";
            1: return "R3 tx_level";
            2: return "R7 tx_ovr";
            3: return "R6 tx_udr";
            4: return "R5 rx_ovr";
            5: return "R4 rx_udr";
            6: return "R8 m_done";
            default: return "R9 s_abort";
        endcase
    endfunction

    function automatic logic [7:0] next_flags(logic [7:0] cur);
        logic [7:0] s, n;
        logic avail, txfull, rxfull;
        avail  = en && txq.size() > 0;
        txfull = txq.size() == D;
        rxfull = rxq.size() == D;
        s    = '0;
        s[0] = txq.size() == 0;
        s[1] = en && (txq.size() < int'(thresh));
        s[2] = wr && en && txfull;
        s[3] = !master && pop && !avail;
        s[4] = !master && push && rxfull;
        s[5] = rd && rxq.size() == 0;
        s[6] = master && cdone && txq.size() == 0;
        s[7] = !master && m_ssq && !ss && m_open;
        n = (cur & ~clr) | s;
        if (flush) begin
            n[3:1] = 3'b000;
            n[0]   = 1'b1;
        end
        return n;
    endfunction

    task automatic check_comb();
        logic avail;
        avail = en && txq.size() > 0;
        chk("R2 R11 eng_tx_avail", 32'(eng_tx_avail), 32'(avail));
        if (avail) chk("R11 tx head order", 32'(eng_tx_data), 32'(txq[0]));
        if (rxq.size() > 0) chk("R11 rx head order", 32'(host_rx_data), 32'(rxq[0]));
        chk("R2 R3 tx_dma_req", 32'(tx_dma_req), 32'(en && (txq.size() < int'(thresh))));
        chk("R5 R6 eng_clk_stall", 32'(eng_clk_stall),
            32'(master && ((pop && !avail) || (push && rxq.size() == D))));
    endtask

    task automatic check_regs();
        chk("R1 R2 R11 tx_count", 32'(tx_count), 32'(txq.size()));
        chk("R11 rx_count", 32'(rx_count), 32'(rxq.size()));
        for (int b = 0; b < 8; b++) chk(ftag(b), 32'(irq_flags[b]), 32'(mflags[b]));
    endtask

    task automatic model_step();
        logic avail, txfull, rxfull, fall;
        avail  = en && txq.size() > 0;
        txfull = txq.size() == D;
        rxfull = rxq.size() == D;
        fall   = m_ssq && !ss;
        mflags = next_flags(mflags);
        if (flush) txq.delete();
        else begin
            if (pop && avail) void'(txq.pop_front());
            if (wr && en && !txfull) txq.push_back(wdata);
        end
        if (rd && rxq.size() > 0) void'(rxq.pop_front());
        if (push && !rxfull) rxq.push_back(pdata);
        if (fall || cdone) m_open = 1'b0;
        else if (btick)    m_open = 1'b1;
        m_ssq = ss;
    endtask

    task automatic idle_inputs();
        flush = 0; en = 1; wr = 0; rd = 0; master = 0; pop = 0; push = 0;
        btick = 0; cdone = 0; ss = 0; thresh = '0; wdata = '0; pdata = '0; clr = '0;
    endtask

    // One cycle: drive at negedge, check combinational, advance model at posedge.
    task automatic run_cycle();
        #1;
        check_comb();
        model_step();
        @(negedge clk);
        check_regs();
    endtask

    initial begin
        idle_inputs();
        mflags = '0; m_ssq = 0; m_open = 0;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // Reset state (R10, R11)
        chk("R10 reset flags", 32'(irq_flags), 32'h0);
        chk("R11 reset tx_count", 32'(tx_count), 32'h0);
        chk("R11 reset rx_count", 32'(rx_count), 32'h0);

        // Directed: fill TX to full, then one more write (R7), threshold edge (R3)
        thresh = CW'(D);
        for (int i = 0; i <= D; i++) begin
            wr = 1; wdata = DW'(8'hA0 + i);
            run_cycle();
        end
        wr = 0;
        chk("R7 directed overflow flag", 32'(irq_flags[2]), 32'h1);
        chk("R3 directed full no dma", 32'(tx_dma_req), 32'h0);
        // Flush (R1)
        flush = 1; run_cycle(); flush = 0;
        chk("R1 directed flush count", 32'(tx_count), 32'h0);
        chk("R1 directed flush ovr cleared", 32'(irq_flags[2]), 32'h0);
        // W1C with set priority (R10): clear tx_empty while queue is empty
        clr = 8'h01; run_cycle(); clr = 8'h00;
        chk("R10 set wins over clear", 32'(irq_flags[0]), 32'h1);
        clr = 8'h04; run_cycle(); clr = 8'h00;

        // Constrained random phase
        for (int cyc = 0; cyc < 4000; cyc++) begin
            flush  = ($urandom % 24) == 0;
            en     = ($urandom % 10) != 0;
            if (cyc % 64 == 0) thresh = CW'($urandom % (D + 1));
            master = ((cyc / 200) % 2) == 1;
            wr     = $urandom % 2;
            wdata  = DW'($urandom);
            rd     = ($urandom % 3) == 0;
            pop    = ($urandom % 3) == 0;
            push   = $urandom % 2;
            pdata  = DW'($urandom);
            clr    = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
            btick  = $urandom % 2;
            cdone  = ($urandom % 5) == 0;
            if (($urandom % 10) == 0) ss = ~ss;
            run_cycle();
        end

        idle_inputs();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule